// File: doc/BRIEF.md
# Serial Bit-Stream Transition Monitor

This block sits behind a clock and data recovery front end and watches the recovered NRZ stream, one bit per clock whenever a valid strobe is high. It measures how much timing information the stream carries. Over a window of programmable length it counts level changes and reports the count as a numerator, with the largest possible count as the denominator. It also keeps a saturating signed DC balance of the stream, the length of the current run of identical bits, and the longest run seen since the last clear.

When a run grows beyond a programmable limit, the block declares that transitions have been lost. While that alarm stands, the forwarded data is replaced by all ones and a hold output tells the downstream timing loop to keep its present frequency and not act on phase error. The first level change clears the alarm. Each run is measured on its own, so long runs separated by a single opposite bit each count separately.

Top module: `nrz_transition_monitor`

## Requirements
- R1: A transition is an accepted bit whose value differs from the previous accepted bit. The monitor counts transitions inside a window of L accepted bits. The first bit of a window is not compared with the last bit of the previous window. On the clock edge that accepts the L-th bit, densValid pulses high for one cycle, densNum takes the window's transition count and densDen takes L-1. The counting then restarts. A programmed length below 2 acts as 2.
- R2: The first bit accepted after reset or after a clear counts no transition and starts a run of length 1.
- R3: disparity is a two's-complement sum. It moves +1 for each accepted 1 and -1 for each accepted 0, and it holds at 2^(DISP_W-1)-1 and -2^(DISP_W-1) instead of wrapping.
- R4: curRun counts consecutive identical accepted bits. It restarts at 1 on a transition and holds at 2^RUN_W-1.
- R5: maxRun holds the largest curRun value reached since reset or the last clear.
- R6: lossAlarm rises on the edge that accepts a bit that makes curRun exceed the run limit. A run equal to the limit raises no alarm.
- R7: lossAlarm falls on the edge that accepts a transition. Long runs separated by a single opposite bit raise the alarm again, each on its own.
- R8: On each accepted bit, dataValid is high one cycle later. dataOut then carries that bit, or 1 if lossAlarm is high after that same edge.
- R9: holdLoop is high exactly while lossAlarm is high.
- R10: measClear, sampled at a clock edge, zeroes disparity, curRun, maxRun, the window counters and the alarm. It takes priority over a bit offered in the same cycle, and that bit is dropped.
- R11: cfgWrite loads cfgWinLen as the window length and cfgRunLimit as the run limit. After reset these are 256 and 72.
- R12: While bitValid is low, curRun, maxRun, disparity and lossAlarm keep their values, and level changes on bitIn are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitValid | input | 1 | Strobe: bitIn carries a recovered bit |
| bitIn | input | 1 | Recovered NRZ bit |
| measClear | input | 1 | Synchronous clear of all measurement state |
| cfgWrite | input | 1 | Load window length and run limit |
| cfgWinLen | input | WIN_W | Window length in bits |
| cfgRunLimit | input | RUN_W | Largest run length tolerated without alarm |
| dataOut | output | 1 | Forwarded bit, all ones during alarm |
| dataValid | output | 1 | dataOut holds a new bit |
| holdLoop | output | 1 | Freeze request for the downstream loop |
| lossAlarm | output | 1 | Loss-of-transitions alarm |
| densValid | output | 1 | One-cycle pulse at the end of each window |
| densNum | output | WIN_W | Transitions counted in the last window |
| densDen | output | WIN_W | Largest possible count in the last window |
| disparity | output | DISP_W | Saturating signed running disparity |
| curRun | output | RUN_W | Length of the current run |
| maxRun | output | RUN_W | Longest run since reset or clear |

## Verification
A wrong previous-bit or first-bit flag shows on the very next accepted bit, because curRun then either restarts at 1 or counts on when it should not. A wrong window counter shows only at the next window boundary, as a densValid pulse arriving early or late or a densNum that does not match the pattern. A wrong alarm state shows on the same edge, in both dataOut and holdLoop. The directed scenarios therefore compare every output after every accepted bit against a bench model, and they stop runs exactly at the limit, at the limit plus one, and at saturation.

// File: rtl/trnmon_pkg.sv
package trnmon_pkg;
  // strobes from control to datapath, valid in the cycle a bit is offered
  typedef struct packed {
    logic take;      // bit accepted this cycle
    logic winTrans;  // transition that counts inside the current window
    logic winEnd;    // accepted bit closes the window
    logic subst;     // alarm state after this edge
    logic clr;       // synchronous measurement clear
  } trnmon_strobe_t;
endpackage

// File: rtl/trnmon_ctrl.sv
module trnmon_ctrl
  import trnmon_pkg::*;
#(
  parameter int WIN_W     = 10,
  parameter int RUN_W     = 16,
  parameter int DEF_WIN   = 256,
  parameter int DEF_LIMIT = 72
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic             measClear,
  input  logic             cfgWrite,
  input  logic [WIN_W-1:0] cfgWinLen,
  input  logic [RUN_W-1:0] cfgRunLimit,
  output trnmon_strobe_t   strb,
  output logic [RUN_W-1:0] runNext,
  output logic [RUN_W-1:0] curRun,
  output logic [WIN_W-1:0] lenM1,
  output logic             lossAlarm
);
  localparam logic [RUN_W-1:0] RUN_MAX   = {RUN_W{1'b1}};
  localparam logic [WIN_W-1:0] WIN_MIN   = WIN_W'(2);
  localparam logic [WIN_W-1:0] WIN_RESET = WIN_W'(DEF_WIN);
  localparam logic [RUN_W-1:0] LIM_RESET = RUN_W'(DEF_LIMIT);

  logic [WIN_W-1:0] winLenReg, effLen, bitCnt;
  logic [RUN_W-1:0] runLimitReg;
  logic             prevBit, haveBit;
  logic             take, first, trans, alarmNext;

  assign effLen = (winLenReg < WIN_MIN) ? WIN_MIN : winLenReg;
  assign lenM1  = effLen - 1'b1;
  assign take   = bitValid & ~measClear;
  assign first  = take & ~haveBit;
  assign trans  = take & haveBit & (bitIn != prevBit);

  always_comb begin
    if (first || trans)      runNext = RUN_W'(1);
    else if (curRun == RUN_MAX) runNext = curRun;
    else                     runNext = curRun + 1'b1;
  end

  always_comb begin
    if (measClear)  alarmNext = 1'b0;
    else if (take)  alarmNext = trans ? 1'b0 : (lossAlarm | (runNext > runLimitReg));
    else            alarmNext = lossAlarm;
  end

  assign strb.take     = take;
  assign strb.winTrans = trans & (bitCnt != '0);
  assign strb.winEnd   = take & (bitCnt >= lenM1);
  assign strb.subst    = alarmNext;
  assign strb.clr      = measClear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winLenReg   <= WIN_RESET;
      runLimitReg <= LIM_RESET;
    end else if (cfgWrite) begin
      winLenReg   <= cfgWinLen;
      runLimitReg <= cfgRunLimit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit   <= 1'b0;
      haveBit   <= 1'b0;
      bitCnt    <= '0;
      curRun    <= '0;
      lossAlarm <= 1'b0;
    end else begin
      lossAlarm <= alarmNext;
      if (measClear) begin
        haveBit <= 1'b0;
        bitCnt  <= '0;
        curRun  <= '0;
      end else if (take) begin
        prevBit <= bitIn;
        haveBit <= 1'b1;
        curRun  <= runNext;
        bitCnt  <= strb.winEnd ? '0 : bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trnmon_dp.sv
module trnmon_dp
  import trnmon_pkg::*;
#(
  parameter int WIN_W  = 10,
  parameter int RUN_W  = 16,
  parameter int DISP_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  trnmon_strobe_t           strb,
  input  logic                     bitIn,
  input  logic [RUN_W-1:0]         runNext,
  input  logic [WIN_W-1:0]         lenM1,
  output logic                     dataOut,
  output logic                     dataValid,
  output logic                     holdLoop,
  output logic                     densValid,
  output logic [WIN_W-1:0]         densNum,
  output logic [WIN_W-1:0]         densDen,
  output logic signed [DISP_W-1:0] disparity,
  output logic [RUN_W-1:0]         maxRun
);
  localparam logic signed [DISP_W-1:0] DISP_HI = {1'b0, {(DISP_W-1){1'b1}}};
  localparam logic signed [DISP_W-1:0] DISP_LO = {1'b1, {(DISP_W-1){1'b0}}};

  logic [WIN_W-1:0] transCnt, transSum;

  assign transSum = transCnt + WIN_W'(strb.winTrans);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      transCnt  <= '0;
      densValid <= 1'b0;
      densNum   <= '0;
      densDen   <= '0;
    end else begin
      densValid <= strb.take & strb.winEnd;
      if (strb.clr) begin
        transCnt <= '0;
      end else if (strb.take) begin
        if (strb.winEnd) begin
          densNum  <= transSum;
          densDen  <= lenM1;
          transCnt <= '0;
        end else begin
          transCnt <= transSum;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disparity <= '0;
      maxRun    <= '0;
    end else if (strb.clr) begin
      disparity <= '0;
      maxRun    <= '0;
    end else if (strb.take) begin
      if (bitIn && disparity != DISP_HI)       disparity <= disparity + 1'b1;
      else if (!bitIn && disparity != DISP_LO) disparity <= disparity - 1'b1;
      if (runNext > maxRun) maxRun <= runNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= 1'b0;
      dataValid <= 1'b0;
      holdLoop  <= 1'b0;
    end else begin
      dataValid <= strb.take;
      holdLoop  <= strb.subst;
      if (strb.take) dataOut <= strb.subst | bitIn;
    end
  end
endmodule

// File: rtl/nrz_transition_monitor.sv
module nrz_transition_monitor
  import trnmon_pkg::*;
#(
  parameter int WIN_W     = 10,
  parameter int RUN_W     = 16,
  parameter int DISP_W    = 16,
  parameter int DEF_WIN   = 256,
  parameter int DEF_LIMIT = 72
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bitValid,
  input  logic                     bitIn,
  input  logic                     measClear,
  input  logic                     cfgWrite,
  input  logic [WIN_W-1:0]         cfgWinLen,
  input  logic [RUN_W-1:0]         cfgRunLimit,
  output logic                     dataOut,
  output logic                     dataValid,
  output logic                     holdLoop,
  output logic                     lossAlarm,
  output logic                     densValid,
  output logic [WIN_W-1:0]         densNum,
  output logic [WIN_W-1:0]         densDen,
  output logic signed [DISP_W-1:0] disparity,
  output logic [RUN_W-1:0]         curRun,
  output logic [RUN_W-1:0]         maxRun
);
  trnmon_strobe_t   strb;
  logic [RUN_W-1:0] runNext;
  logic [WIN_W-1:0] lenM1;

  trnmon_ctrl #(
    .WIN_W(WIN_W), .RUN_W(RUN_W), .DEF_WIN(DEF_WIN), .DEF_LIMIT(DEF_LIMIT)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .measClear(measClear), .cfgWrite(cfgWrite), .cfgWinLen(cfgWinLen),
    .cfgRunLimit(cfgRunLimit), .strb(strb), .runNext(runNext),
    .curRun(curRun), .lenM1(lenM1), .lossAlarm(lossAlarm)
  );

  trnmon_dp #(
    .WIN_W(WIN_W), .RUN_W(RUN_W), .DISP_W(DISP_W)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(bitIn), .runNext(runNext),
    .lenM1(lenM1), .dataOut(dataOut), .dataValid(dataValid),
    .holdLoop(holdLoop), .densValid(densValid), .densNum(densNum),
    .densDen(densDen), .disparity(disparity), .maxRun(maxRun)
  );
endmodule

// File: rtl/trnmon_chk.sv
module trnmon_chk #(
  parameter int WIN_W  = 10,
  parameter int RUN_W  = 16,
  parameter int DISP_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     bitValid,
  input logic                     bitIn,
  input logic                     measClear,
  input logic                     dataOut,
  input logic                     holdLoop,
  input logic                     lossAlarm,
  input logic                     densValid,
  input logic [WIN_W-1:0]         densNum,
  input logic [WIN_W-1:0]         densDen,
  input logic signed [DISP_W-1:0] disparity,
  input logic [RUN_W-1:0]         curRun,
  input logic [RUN_W-1:0]         maxRun
);
  localparam logic signed [DISP_W-1:0] DISP_HI = {1'b0, {(DISP_W-1){1'b1}}};
  localparam logic [RUN_W-1:0]         ONE_RUN = {{(RUN_W-1){1'b0}}, 1'b1};

  // R1
  dens_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    densValid |-> (densNum <= densDen) && (densDen != '0));
  // R3
  disp_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !measClear && bitIn && disparity != DISP_HI) |=> disparity > $past(disparity));
  // R4
  run_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !measClear) |=>
      (curRun == ONE_RUN) || (curRun == $past(curRun) + ONE_RUN) || (curRun == $past(curRun)));
  // R5
  max_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    maxRun >= curRun);
  // R6
  alarm_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossAlarm |-> curRun != '0);
  // R7
  alarm_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossAlarm) |-> curRun <= ONE_RUN);
  // R8
  subst_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    lossAlarm |-> dataOut);
  // R9
  hold_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdLoop == lossAlarm);
  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    measClear |=> curRun == '0 && maxRun == '0 && disparity == '0 && !lossAlarm);
  // R12
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !measClear) |=>
      $stable(curRun) && $stable(maxRun) && $stable(disparity) && $stable(lossAlarm));
endmodule

bind nrz_transition_monitor trnmon_chk #(
  .WIN_W(WIN_W), .RUN_W(RUN_W), .DISP_W(DISP_W)
) chkI (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
  .measClear(measClear), .dataOut(dataOut), .holdLoop(holdLoop),
  .lossAlarm(lossAlarm), .densValid(densValid), .densNum(densNum),
  .densDen(densDen), .disparity(disparity), .curRun(curRun), .maxRun(maxRun)
);

// File: tb/nrz_transition_monitor_tb_top.sv
module nrz_transition_monitor_tb_top;
  localparam int WIN_W = 10, RUN_W = 8, DISP_W = 6;
  localparam int RUNMAX = 255, DHI = 31, DLO = -32;

  logic clk = 1'b0, rstN = 1'b0;
  logic bitValid = 1'b0, bitIn = 1'b0, measClear = 1'b0, cfgWrite = 1'b0;
  logic [WIN_W-1:0] cfgWinLen = '0;
  logic [RUN_W-1:0] cfgRunLimit = '0;
  logic dataOut, dataValid, holdLoop, lossAlarm, densValid;
  logic [WIN_W-1:0] densNum, densDen;
  logic signed [DISP_W-1:0] disparity;
  logic [RUN_W-1:0] curRun, maxRun;

  nrz_transition_monitor #(.WIN_W(WIN_W), .RUN_W(RUN_W), .DISP_W(DISP_W)) dut_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .measClear(measClear), .cfgWrite(cfgWrite), .cfgWinLen(cfgWinLen),
    .cfgRunLimit(cfgRunLimit), .dataOut(dataOut), .dataValid(dataValid),
    .holdLoop(holdLoop), .lossAlarm(lossAlarm), .densValid(densValid),
    .densNum(densNum), .densDen(densDen), .disparity(disparity),
    .curRun(curRun), .maxRun(maxRun)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  // bench model of the requirements
  int mPrev = 0, mHave = 0, mRun = 0, mMax = 0, mDisp = 0, mAlarm = 0, mData = 0;
  int mCnt = 0, mT = 0, mWin = 256, mLimit = 72, mNum = 0, mDen = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushBit(input int b);
    int eff, tr, dv;
    bitValid = 1'b1;
    bitIn = b[0];
    @(posedge clk);
    #1;
    bitValid = 1'b0;
    tr = (mHave != 0 && b != mPrev) ? 1 : 0;
    if (mHave == 0 || tr != 0) mRun = 1;
    else if (mRun < RUNMAX) mRun++;
    if (mRun > mMax) mMax = mRun;
    if (b != 0) mDisp = (mDisp == DHI) ? DHI : mDisp + 1;
    else        mDisp = (mDisp == DLO) ? DLO : mDisp - 1;
    if (tr != 0) mAlarm = 0;
    else if (mRun > mLimit) mAlarm = 1;
    mData = (mAlarm != 0) ? 1 : b;
    eff = (mWin < 2) ? 2 : mWin;
    if (mCnt != 0 && tr != 0) mT++;
    dv = 0;
    if (mCnt >= eff - 1) begin
      dv = 1; mNum = mT; mDen = eff - 1; mCnt = 0; mT = 0;
    end else mCnt++;
    mPrev = b;
    mHave = 1;
    check("R4 curRun", int'(curRun), mRun);
    check("R5 maxRun", int'(maxRun), mMax);
    check("R3 disparity", int'(disparity), mDisp);
    check("R6 R7 lossAlarm", int'(lossAlarm), mAlarm);
    check("R9 holdLoop", int'(holdLoop), mAlarm);
    check("R8 dataOut", int'(dataOut), mData);
    check("R8 dataValid", int'(dataValid), 1);
    check("R1 densValid", int'(densValid), dv);
    if (dv != 0) begin
      check("R1 densNum", int'(densNum), mNum);
      check("R1 densDen", int'(densDen), mDen);
    end
  endtask

  task automatic pushRun(input int b, input int n);
    for (int i = 0; i < n; i++) pushBit(b);
  endtask

  task automatic doClear();
    measClear = 1'b1;
    bitValid = 1'b1;
    bitIn = ~bitIn;
    @(posedge clk);
    #1;
    measClear = 1'b0;
    bitValid = 1'b0;
    mHave = 0; mRun = 0; mMax = 0; mDisp = 0; mAlarm = 0; mCnt = 0; mT = 0;
    check("R10 clear curRun", int'(curRun), 0);
    check("R10 clear maxRun", int'(maxRun), 0);
    check("R10 clear disparity", int'(disparity), 0);
    check("R10 clear lossAlarm", int'(lossAlarm), 0);
    check("R10 clear holdLoop", int'(holdLoop), 0);
    check("R10 clear dataValid", int'(dataValid), 0);
  endtask

  task automatic doConfig(input int win, input int lim);
    cfgWrite = 1'b1;
    cfgWinLen = WIN_W'(win);
    cfgRunLimit = RUN_W'(lim);
    @(posedge clk);
    #1;
    cfgWrite = 1'b0;
    mWin = win;
    mLimit = lim;
  endtask

  task automatic testReset();
    check("R11 reset curRun", int'(curRun), 0);
    check("R11 reset maxRun", int'(maxRun), 0);
    check("R11 reset disparity", int'(disparity), 0);
    check("R11 reset lossAlarm", int'(lossAlarm), 0);
    check("R11 reset holdLoop", int'(holdLoop), 0);
    check("R11 reset densValid", int'(densValid), 0);
    check("R11 reset dataValid", int'(dataValid), 0);
  endtask

  task automatic testFirstBit();
    pushBit(1);
    check("R2 first run", int'(curRun), 1);
    check("R2 first disparity", int'(disparity), 1);
  endtask

  task automatic testDefaultWindow();
    // 255 more alternating bits close the default 256-bit window
    for (int i = 0; i < 255; i++) pushBit((i % 2 == 0) ? 0 : 1);
    check("R11 default window num", int'(densNum), 255);
    check("R11 default window den", int'(densDen), 255);
  endtask

  task automatic testDensity();
    doConfig(8, 72);
    doClear();
    for (int i = 0; i < 8; i++) pushBit(i % 2);
    check("R1 alternating num", int'(densNum), 7);
    pushRun(1, 8);
    check("R1 constant num", int'(densNum), 0);
    for (int i = 0; i < 8; i++) pushBit((i / 2) % 2);
    check("R1 pairs num", int'(densNum), 3);
    check("R1 pairs den", int'(densDen), 7);
    doConfig(1, 72);
    doClear();
    pushBit(0);
    pushBit(1);
    check("R1 short window den", int'(densDen), 1);
    doConfig(64, 72);
  endtask

  task automatic testCid();
    doClear();
    pushBit(1);
    pushRun(0, 72);
    check("R6 limit run no alarm", int'(lossAlarm), 0);
    pushBit(0);
    check("R6 limit plus one alarm", int'(lossAlarm), 1);
    check("R8 substituted ones", int'(dataOut), 1);
    pushRun(0, 5);
    pushBit(1);
    check("R7 cleared by transition", int'(lossAlarm), 0);
    check("R7 run restart", int'(curRun), 1);
    pushRun(0, 73);
    check("R7 second run alarm", int'(lossAlarm), 1);
    check("R9 second run hold", int'(holdLoop), 1);
    pushBit(1);
    check("R7 second clear", int'(lossAlarm), 0);
  endtask

  task automatic testDisparity();
    doClear();
    pushRun(1, 40);
    check("R3 upper saturation", int'(disparity), DHI);
    pushRun(0, 80);
    check("R3 lower saturation", int'(disparity), DLO);
    pushBit(1);
    check("R3 leaves lower bound", int'(disparity), DLO + 1);
  endtask

  task automatic testRunSat();
    doConfig(64, RUNMAX);
    doClear();
    pushRun(1, 300);
    check("R4 run saturates", int'(curRun), RUNMAX);
    check("R5 max saturated", int'(maxRun), RUNMAX);
    pushBit(0);
    check("R5 max held after new run", int'(maxRun), RUNMAX);
    doConfig(64, 72);
  endtask

  task automatic testIdle();
    int r, d, m;
    doClear();
    pushRun(0, 3);
    r = int'(curRun); d = int'(disparity); m = int'(maxRun);
    for (int i = 0; i < 6; i++) begin
      bitIn = i[0];
      @(posedge clk);
      #1;
    end
    check("R12 idle curRun", int'(curRun), r);
    check("R12 idle disparity", int'(disparity), d);
    check("R12 idle maxRun", int'(maxRun), m);
    check("R12 idle dataValid", int'(dataValid), 0);
    pushBit(0);
    check("R12 run continues", int'(curRun), 4);
  endtask

  task automatic testClear();
    pushRun(1, 80);
    check("R10 alarm before clear", int'(lossAlarm), 1);
    doClear();
    pushBit(1);
    check("R2 first after clear", int'(curRun), 1);
    check("R10 disparity after clear", int'(disparity), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    @(posedge clk);
    #1;
    testReset();
    testFirstBit();
    testDefaultWindow();
    testDensity();
    testCid();
    testDisparity();
    testRunSat();
    testIdle();
    testClear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule